// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves a block of words from an I/O data source into memory without the processor touching each word. Software first writes a start word address and a word count into two configuration registers. It then writes a go bit into a control register. The controller latches both values into working counters and raises a bus request. After the system arbiter grants the bus, it copies one word per cycle from the source to memory, whenever the source offers data and memory accepts it. Each accepted word goes to the next word address.

When the last word is written, the controller drops its bus request and raises a completion interrupt. The interrupt stays high until software acknowledges it through the control register. A zero count finishes at once: the interrupt is raised and the bus is never requested. If the arbiter takes the grant away in the middle of a transfer, the controller stops and keeps requesting. It carries on from the same address once the grant comes back.

The controller has three states. In `ST_IDLE` it waits for a go write. In `ST_REQ` it requests the bus and waits for the grant. In `ST_MOVE` it owns the bus and moves words. The transitions are as follows:
- IDLE→REQ: go with a nonzero count.
- IDLE→IDLE: go with a zero count (the interrupt is raised).
- REQ→MOVE: grant seen.
- MOVE→REQ: grant lost.
- MOVE→IDLE: the last word is accepted (the interrupt is raised).

Top module: `dma_engine`

## Requirements
- R1: After reset, bus_req, mem_we, src_ready and irq are all low.
- R2: Register map on cfg_addr: 0 = start word address, 1 = word count, 2 = control, where control bit 0 is go and bit 1 is interrupt acknowledge. A go write with a nonzero count raises bus_req from the next cycle.
- R3: A word moves only while the bus is owned and bus_gnt is high. In that condition mem_we follows src_valid, src_ready follows mem_ready, and a word is transferred when mem_we and mem_ready are both high. mem_wdata carries src_data.
- R4: The first word is written to the start address, and each following word to the previous address plus one, wrapping modulo 2^AW.
- R5: Exactly the programmed number of words is written. In the cycle after the last one, bus_req is low and irq is high.
- R6: A go write with a count of zero sets irq in the next cycle, and bus_req stays low.
- R7: Once set, irq stays high until a control write with bit 1 set. That write clears it in the next cycle.
- R8: A go write while a transfer is in progress is ignored, including a count written beforehand. The running transfer completes with its original count, and no second transfer follows.
- R9: If bus_gnt drops while the bus is owned, no words move and bus_req stays high. The transfer resumes at the next address when the grant returns.
- R10: A write to cfg_addr 3 has no effect: it neither starts a transfer nor clears irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | RW | Configuration write data (RW = max(AW, CW)) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Source word taken when src_valid is also high |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| irq | output | 1 | Completion interrupt, level |

## Verification
The checker looks at every cycle for the following:
- a memory write or source acceptance without bus ownership and grant;
- an address that does not step by one after each accepted word;
- an interrupt that falls without an acknowledge;
- a bus request that falls without the interrupt being set.

The exact word count, the address and data sequence, and the zero-count shortcut come from the bench's scenarios. So do the ignored mid-transfer go, the pause on grant loss and the dead register slot. The bench shows these by replaying transfers with varied source, memory and grant patterns and comparing each write with a model it keeps itself.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_MOVE = 2'd2
    } dma_state_e;

    localparam logic [1:0] REG_BASE  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_ACK_BIT = 1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    localparam int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic [AW-1:0] base_q,
    output logic [CW-1:0] count_q,
    output logic          go_pulse,
    output logic          ack_pulse
);

    logic ctrl_sel;

    assign ctrl_sel  = cfg_we && (cfg_addr == REG_CTRL);
    assign go_pulse  = ctrl_sel && cfg_wdata[CTRL_GO_BIT];
    assign ack_pulse = ctrl_sel && cfg_wdata[CTRL_ACK_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == REG_BASE)  base_q  <= cfg_wdata[AW-1:0];
            if (cfg_addr == REG_COUNT) count_q <= cfg_wdata[CW-1:0];
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] STEP_ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= load_val;
        else if (step) addr_q <= addr_q + STEP_ONE;
    end

endmodule

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    remain_q <= '0;
        else if (load) remain_q <= load_val;
        else if (step) remain_q <= remain_q - ONE;
    end

    assign last = (remain_q == ONE);

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ack,
    input  logic cnt_zero,
    input  logic last_word,
    input  logic bus_gnt,
    input  logic src_valid,
    input  logic mem_ready,
    output logic load,
    output logic fire,
    output logic bus_req,
    output logic src_ready,
    output logic mem_we,
    output logic irq
);

    dma_state_e state_q, state_d;
    logic       done;
    logic       own;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go && !cnt_zero) state_d = ST_REQ;
            ST_REQ:  if (bus_gnt)         state_d = ST_MOVE;
            ST_MOVE: begin
                if (fire && last_word) state_d = ST_IDLE;
                else if (!bus_gnt)     state_d = ST_REQ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        bus_req   = 1'b0;
        own       = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = go;
                done = go && cnt_zero;
            end
            ST_REQ: begin
                bus_req = 1'b1;
            end
            ST_MOVE: begin
                bus_req = 1'b1;
                own     = bus_gnt;
            end
            default: ;
        endcase
        mem_we    = own && src_valid;
        src_ready = own && mem_ready;
        fire      = own && src_valid && mem_ready;
        if (fire && last_word) done = 1'b1;
    end

    // interrupt: completion wins over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)    irq <= 1'b0;
        else if (done) irq <= 1'b1;
        else if (ack)  irq <= 1'b0;
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32,
    localparam int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    output logic          irq
);

    logic [AW-1:0] base_q;
    logic [CW-1:0] count_q;
    logic          go_pulse, ack_pulse;
    logic          load, fire, last_word;

    dma_cfg_regs #(.AW(AW), .CW(CW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .count_q   (count_q),
        .go_pulse  (go_pulse),
        .ack_pulse (ack_pulse)
    );

    dma_addr_gen #(.AW(AW)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (base_q),
        .step     (fire),
        .addr_q   (mem_addr)
    );

    dma_word_ctr #(.CW(CW)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (count_q),
        .step     (fire),
        .last     (last_word)
    );

    dma_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_pulse),
        .ack       (ack_pulse),
        .cnt_zero  (count_q == '0),
        .last_word (last_word),
        .bus_gnt   (bus_gnt),
        .src_valid (src_valid),
        .mem_ready (mem_ready),
        .load      (load),
        .fire      (fire),
        .bus_req   (bus_req),
        .src_ready (src_ready),
        .mem_we    (mem_we),
        .irq       (irq)
    );

    assign mem_wdata = src_data;

endmodule

module dma_engine_chk #(
    parameter int AW = 16,
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_addr,
    input logic [RW-1:0] cfg_wdata,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          src_valid,
    input logic          src_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          irq
);

    logic ack_wr;
    assign ack_wr = cfg_we && (cfg_addr == 2'd2) && cfg_wdata[1];

    // R3
    we_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bus_req && bus_gnt && src_valid));

    // R3
    take_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (bus_req && bus_gnt && mem_ready));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready) |=> (mem_addr == $past(mem_addr) + AW'(1)));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> irq);

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .RW(RW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .irq       (irq)
);

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 32;
    localparam int RW = 16;

    // row: base[47:32] count[31:24] valid_mask[23:16] ready_mask[15:8] grant_delay[7:0]
    localparam int NVEC = 5;
    localparam logic [47:0] VEC [0:NVEC-1] = '{
        {16'h0100, 8'd4, 8'hFF,        8'hFF,        8'd0},
        {16'h2000, 8'd7, 8'b1011_0110, 8'hFF,        8'd2},
        {16'h00FE, 8'd5, 8'hFF,        8'b0101_0101, 8'd1},
        {16'hFFFE, 8'd3, 8'b1100_1101, 8'b1110_0111, 8'd3},
        {16'h0040, 8'd1, 8'hFF,        8'hFF,        8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b0;
    logic          irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dma_engine #(.AW(AW), .CW(CW), .DW(DW)) i_dma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] b, input int n);
        return {b, 16'h0000} + DW'(n);
    endfunction

    // drives words until total reached; called at a negedge
    task automatic drive_words(input logic [AW-1:0] base, input int first,
                               input int cnt, input logic [7:0] vm,
                               input logic [7:0] rm, input int gd);
        int words = first;
        int i = 0;
        while (words < cnt && i < 400) begin
            bus_gnt   = (i >= gd);
            src_valid = vm[i % 8];
            mem_ready = rm[i % 8];
            src_data  = word_of(base, words);
            #1;
            if (!bus_gnt) chk(!mem_we, "R3 write without grant", 32'(mem_we), 0);
            if (mem_we && mem_ready) begin
                chk(mem_addr == base + AW'(words), "R4 address", 32'(mem_addr),
                    32'(base + AW'(words)));
                chk(mem_wdata == word_of(base, words), "R3 data", mem_wdata,
                    word_of(base, words));
                words++;
            end
            i++;
            @(negedge clk);
        end
        chk(words == cnt, "R5 word count", 32'(words), 32'(cnt));
        bus_gnt = 1'b0; src_valid = 1'b0; mem_ready = 1'b0;
        #1;
        chk(!bus_req, "R5 request dropped", 32'(bus_req), 0);
        chk(irq, "R5 irq after last", 32'(irq), 1);
        chk(!mem_we, "R5 no write after last", 32'(mem_we), 0);
    endtask

    task automatic clear_irq();
        cfg_write(2'd2, RW'(2));
        chk(!irq, "R7 ack clears irq", 32'(irq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bus_req && !mem_we && !src_ready && !irq, "R1 reset",
            {28'd0, bus_req, mem_we, src_ready, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !irq, "R1 after release", {30'd0, bus_req, irq}, 0);

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            logic [AW-1:0] b;
            b = VEC[k][47:32];
            cfg_write(2'd0, b);
            cfg_write(2'd1, RW'(VEC[k][31:24]));
            cfg_write(2'd2, RW'(1));
            chk(bus_req, "R2 request after go", 32'(bus_req), 1);
            chk(!mem_we, "R3 no write before grant", 32'(mem_we), 0);
            drive_words(b, 0, int'(VEC[k][31:24]), VEC[k][23:16], VEC[k][15:8],
                        int'(VEC[k][7:0]));
            repeat (3) @(negedge clk);
            chk(irq, "R7 irq held", 32'(irq), 1);
            clear_irq();
        end

        // R6 zero count
        cfg_write(2'd1, RW'(0));
        cfg_write(2'd2, RW'(1));
        chk(irq, "R6 zero count irq", 32'(irq), 1);
        for (int j = 0; j < 3; j++) begin
            chk(!bus_req, "R6 no request", 32'(bus_req), 0);
            @(negedge clk);
        end
        // R10 dead slot neither clears nor starts
        cfg_write(2'd3, '1);
        chk(irq, "R10 slot 3 keeps irq", 32'(irq), 1);
        chk(!bus_req, "R10 slot 3 no start", 32'(bus_req), 0);
        clear_irq();
        cfg_write(2'd1, RW'(2));
        cfg_write(2'd3, '1);
        @(negedge clk);
        chk(!bus_req, "R10 slot 3 go ignored", 32'(bus_req), 0);

        // R8 go while busy ignored
        cfg_write(2'd0, 16'h0300);
        cfg_write(2'd1, RW'(3));
        cfg_write(2'd2, RW'(1));
        cfg_write(2'd1, RW'(9));
        cfg_write(2'd2, RW'(1));
        chk(bus_req, "R8 still requesting", 32'(bus_req), 1);
        drive_words(16'h0300, 0, 3, 8'hFF, 8'hFF, 0);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk(!bus_req, "R8 no second transfer", 32'(bus_req), 0);
        end
        clear_irq();

        // R9 grant loss pauses
        begin
            int seen = 0;
            int guard = 0;
            cfg_write(2'd0, 16'h0500);
            cfg_write(2'd1, RW'(4));
            cfg_write(2'd2, RW'(1));
            while (seen < 2 && guard < 20) begin
                bus_gnt = 1'b1; src_valid = 1'b1; mem_ready = 1'b1;
                src_data = word_of(16'h0500, seen);
                #1;
                if (mem_we && mem_ready) begin
                    chk(mem_addr == 16'h0500 + AW'(seen), "R9 address",
                        32'(mem_addr), 32'(16'h0500 + seen));
                    seen++;
                end
                guard++;
                @(negedge clk);
            end
            bus_gnt = 1'b0;
            for (int j = 0; j < 3; j++) begin
                #1;
                chk(!mem_we, "R9 paused no write", 32'(mem_we), 0);
                chk(bus_req, "R9 request held", 32'(bus_req), 1);
                @(negedge clk);
            end
            drive_words(16'h0500, 2, 4, 8'hFF, 8'hFF, 0);
            clear_irq();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule